// File: doc/BRIEF.md
# Voice Trigger Mode Controller

This block sits between the trigger pins of a voice playback device and its playback sequencer. Each cycle it decides whether to start a voice group, abort the group in progress, or report that a group has finished. The sequencer receives a start pulse with a group number and returns a busy level while it plays. A chip-wide mode input selects how the groups are addressed. In key mode, the eight trigger inputs are read as a binary code, and a separate sequential input steps through the groups in turn. In CPU mode, a strobe captures a 5-bit group address.

Each group has four option bits of its own. These choose edge or level triggering, holdable or unholdable triggering, retriggerable or non-retriggerable behaviour, and whether a stop pulse is sent when playback ends. A group that uses level triggering and unholdable triggering also allows overlap: a new trigger for a different group cuts it short. Input debouncing is done outside this block.

Top module: `vtrig_ctrl`

## Requirements
- R1: After reset, start, abort and stop_pulse are low, group reads 0, and the sequential pointer points at group 0. Reset can be applied again while the block is running.
- R2: In key mode (cpu_mode=0), a key_in value k with 1 <= k <= 32 selects group k-1. When the block is idle, a new code causes a start pulse one cycle later, with group = k-1. The value 0 and the values 33 to 255 select nothing and cause no start.
- R3: In CPU mode (cpu_mode=1), a rising edge of strobe captures addr and starts that group one cycle later. A change of addr while strobe stays high has no effect. key_in and seq_in have no effect in CPU mode.
- R4: In key mode, each rising edge of seq_in that leads to a start plays the group at the pointer and then advances the pointer. The pointer wraps from group 31 to group 0. A seq_in edge that is ignored does not advance the pointer.
- R5: An edge group (opt_level bit 0) starts once for each new appearance of its code. Holding the code after playback ends does not play the group again.
- R6: A level group (opt_level bit 1) starts while its code is held. If the code is still held when playback ends, the group starts again one cycle after the end is seen.
- R7: For a level group that is holdable (opt_hold bit 1), removing the trigger during playback gives an abort pulse one cycle later. In CPU mode the trigger is removed by strobe going low. For an unholdable level group, removing the trigger gives no abort.
- R8: For an edge group that is holdable, a new trigger of the same group during playback gives an abort pulse instead of a restart.
- R9: During playback, a new trigger of the same group restarts it (a start pulse with the same group) when opt_retrig is set for that group. When the bit is clear, the trigger is ignored.
- R10: During playback, a new trigger of a different group starts that group only when the playing group is level and unholdable (overlap). Otherwise the trigger is ignored.
- R11: When busy falls and ends playback, stop_pulse is high for one cycle, on the cycle after busy is first seen low, if opt_stop is set for the group that was playing. There is no stop pulse when the bit is clear or after an abort.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_mode | input | 1 | 0 selects key mode, 1 selects CPU mode |
| key_in | input | 8 | Trigger code in key mode |
| seq_in | input | 1 | Sequential trigger in key mode |
| strobe | input | 1 | Address strobe in CPU mode |
| addr | input | 5 | Group address in CPU mode |
| opt_level | input | 32 | Per group: 1 = level trigger, 0 = edge trigger |
| opt_hold | input | 32 | Per group: 1 = holdable |
| opt_retrig | input | 32 | Per group: 1 = retriggerable |
| opt_stop | input | 32 | Per group: 1 = stop pulse enabled |
| busy | input | 1 | High while the sequencer is playing |
| start | output | 1 | One-cycle start command |
| group | output | 5 | Group that is started or playing |
| abort | output | 1 | One-cycle abort command |
| stop_pulse | output | 1 | One-cycle end-of-playback pulse |

## Verification
A start or an abort is due one cycle after the trigger input that causes it. The bench drives inputs on the falling edge and samples at the next falling edge, so exactly one rising edge lies between stimulus and check. A stop pulse is due one cycle after busy is first driven low. The replay of a held level group is due one cycle after that, so the bench samples it at the second falling edge after busy drops. Ignored triggers are checked at the same one-cycle point, where start and abort must both be low and group must still show the playing group.

// File: rtl/vtrig_pkg.sv
package vtrig_pkg;
  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_START = 2'd1,
    ACT_ABORT = 2'd2,
    ACT_DONE  = 2'd3
  } vt_act_e;
endpackage

// File: rtl/vtrig_src.sv
// Merges the key code and the CPU strobe/address into a single trigger
// source, and detects rising edges of the sequential input.
module vtrig_src #(
  parameter int N_GRP = 32,
  parameter int KEY_W = 8,
  parameter int GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_mode,
  input  logic [KEY_W-1:0] key_in,
  input  logic             seq_in,
  input  logic             strobe,
  input  logic [GRP_W-1:0] addr,
  output logic             src_valid,
  output logic [GRP_W-1:0] src_grp,
  output logic             src_fresh,
  output logic             seq_evt
);

  function automatic logic key_ok(input logic [KEY_W-1:0] k);
    return (int'(k) >= 1) && (int'(k) <= N_GRP);
  endfunction

  function automatic logic [GRP_W-1:0] key_grp(input logic [KEY_W-1:0] k);
    return GRP_W'(int'(k) - 1);
  endfunction

  logic             strobe_q, seq_q, prev_valid;
  logic [GRP_W-1:0] addr_q, prev_grp;
  logic             strobe_rise;

  assign strobe_rise = cpu_mode & strobe & ~strobe_q;

  always_comb begin
    if (cpu_mode) begin
      src_grp   = strobe_rise ? addr : addr_q;
      src_valid = strobe & (int'(src_grp) < N_GRP);
    end else begin
      src_grp   = key_grp(key_in);
      src_valid = key_ok(key_in);
    end
  end

  assign src_fresh = src_valid & (~prev_valid | (prev_grp != src_grp));
  assign seq_evt   = ~cpu_mode & seq_in & ~seq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q   <= 1'b0;
      seq_q      <= 1'b0;
      prev_valid <= 1'b0;
      prev_grp   <= '0;
      addr_q     <= '0;
    end else begin
      strobe_q   <= strobe;
      seq_q      <= seq_in;
      prev_valid <= src_valid;
      prev_grp   <= src_grp;
      if (strobe_rise) addr_q <= addr;
    end
  end

  // R3: the strobe edge captures the address
  a_r3_addr_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_mode && strobe && !strobe_q) |=> (addr_q == $past(addr)));

  // R2: a code held steady is fresh only once
  a_r2_fresh_once: assert property (@(posedge clk) disable iff (!rst_n)
    src_fresh |=> !(src_fresh && (src_grp == $past(src_grp))));

endmodule

// File: rtl/vtrig_ptr.sv
// Sequential group pointer, wrapping at N_GRP.
module vtrig_ptr #(
  parameter int N_GRP = 32,
  parameter int GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [GRP_W-1:0] ptr
);

  localparam logic [GRP_W-1:0] LAST = GRP_W'(N_GRP - 1);

  logic [GRP_W-1:0] ptr_nxt;

  generate
    if ((1 << GRP_W) == N_GRP) begin : g_pow2
      assign ptr_nxt = ptr + 1'b1;
    end else begin : g_wrap
      assign ptr_nxt = (ptr == LAST) ? '0 : ptr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ptr <= '0;
    else if (adv) ptr <= ptr_nxt;
  end

  // R4: the pointer wraps from the last group to the first
  a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && ptr == LAST) |=> (ptr == '0));

  // R4: the pointer moves only when a sequential start is taken
  a_r4_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(ptr));

endmodule

// File: rtl/vtrig_core.sv
// Decides start / abort / done each cycle from the trigger events, the
// per-group options and the busy level returned by the sequencer.
module vtrig_core
  import vtrig_pkg::*;
#(
  parameter int N_GRP = 32,
  parameter int GRP_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_GRP-1:0] opt_level,
  input  logic [N_GRP-1:0] opt_hold,
  input  logic [N_GRP-1:0] opt_retrig,
  input  logic [N_GRP-1:0] opt_stop,
  input  logic             busy,
  input  logic             src_valid,
  input  logic [GRP_W-1:0] src_grp,
  input  logic             src_fresh,
  input  logic             seq_evt,
  input  logic [GRP_W-1:0] seq_grp,
  output logic             start_o,
  output logic             abort_o,
  output logic             stop_o,
  output logic [GRP_W-1:0] grp_o,
  output logic             ptr_adv
);

  logic             run, run_src, busy_q;
  logic [GRP_W-1:0] cur;

  logic             ev_any, ev_src;
  logic [GRP_W-1:0] ev_grp;
  logic             lvl_c, hold_c, retrig_c, held_c;

  vt_act_e          act;
  logic [GRP_W-1:0] nxt_grp;
  logic             nxt_src;

  // key/strobe trigger wins over the sequential input in the same cycle
  assign ev_any   = src_fresh | seq_evt;
  assign ev_src   = src_fresh;
  assign ev_grp   = src_fresh ? src_grp : seq_grp;

  assign lvl_c    = opt_level[cur];
  assign hold_c   = opt_hold[cur];
  assign retrig_c = opt_retrig[cur];
  assign held_c   = src_valid && (src_grp == cur);

  always_comb begin
    act     = ACT_NONE;
    nxt_grp = ev_grp;
    nxt_src = ev_src;
    if (!run) begin
      if (ev_any) begin
        act = ACT_START;
      end else if (src_valid && opt_level[src_grp]) begin
        act     = ACT_START;
        nxt_grp = src_grp;
        nxt_src = 1'b1;
      end
    end else begin
      if (run_src && lvl_c && hold_c && !held_c) begin
        act = ACT_ABORT;
      end else if (ev_any && ev_grp == cur) begin
        if (!lvl_c && hold_c) act = ACT_ABORT;
        else if (retrig_c)    act = ACT_START;
      end else if (ev_any && lvl_c && !hold_c) begin
        act = ACT_START;
      end
      if (act == ACT_NONE && busy_q && !busy) act = ACT_DONE;
    end
  end

  assign ptr_adv = (act == ACT_START) && !nxt_src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      run_src <= 1'b0;
      cur     <= '0;
      busy_q  <= 1'b0;
      start_o <= 1'b0;
      abort_o <= 1'b0;
      stop_o  <= 1'b0;
    end else begin
      busy_q  <= busy;
      start_o <= (act == ACT_START);
      abort_o <= (act == ACT_ABORT);
      stop_o  <= (act == ACT_DONE) && opt_stop[cur];
      case (act)
        ACT_START: begin
          run     <= 1'b1;
          run_src <= nxt_src;
          cur     <= nxt_grp;
        end
        ACT_ABORT, ACT_DONE: run <= 1'b0;
        default: ;
      endcase
    end
  end

  assign grp_o = cur;

  // R7: removing the trigger of a holdable level run aborts it next cycle
  a_r7_release_aborts: assert property (@(posedge clk) disable iff (!rst_n)
    (run && run_src && opt_level[cur] && opt_hold[cur] &&
     !(src_valid && src_grp == cur)) |=> abort_o);

  // R11: a stop pulse follows a high-to-low step of busy
  a_r11_stop_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    stop_o |-> (!$past(busy) && $past(busy, 2)));

endmodule

// File: rtl/vtrig_ctrl.sv
module vtrig_ctrl #(
  parameter int N_GRP = 32,
  parameter int KEY_W = 8,
  localparam int GRP_W = $clog2(N_GRP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_mode,
  input  logic [KEY_W-1:0] key_in,
  input  logic             seq_in,
  input  logic             strobe,
  input  logic [GRP_W-1:0] addr,
  input  logic [N_GRP-1:0] opt_level,
  input  logic [N_GRP-1:0] opt_hold,
  input  logic [N_GRP-1:0] opt_retrig,
  input  logic [N_GRP-1:0] opt_stop,
  input  logic             busy,
  output logic             start,
  output logic [GRP_W-1:0] group,
  output logic             abort,
  output logic             stop_pulse
);

  logic             src_valid, src_fresh, seq_evt, ptr_adv;
  logic [GRP_W-1:0] src_grp, seq_grp;

  vtrig_src #(.N_GRP(N_GRP), .KEY_W(KEY_W), .GRP_W(GRP_W)) u_src (
    .clk(clk), .rst_n(rst_n), .cpu_mode(cpu_mode), .key_in(key_in),
    .seq_in(seq_in), .strobe(strobe), .addr(addr),
    .src_valid(src_valid), .src_grp(src_grp), .src_fresh(src_fresh),
    .seq_evt(seq_evt)
  );

  vtrig_ptr #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .adv(ptr_adv), .ptr(seq_grp)
  );

  vtrig_core #(.N_GRP(N_GRP), .GRP_W(GRP_W)) u_core (
    .clk(clk), .rst_n(rst_n),
    .opt_level(opt_level), .opt_hold(opt_hold),
    .opt_retrig(opt_retrig), .opt_stop(opt_stop),
    .busy(busy), .src_valid(src_valid), .src_grp(src_grp),
    .src_fresh(src_fresh), .seq_evt(seq_evt), .seq_grp(seq_grp),
    .start_o(start), .abort_o(abort), .stop_o(stop_pulse),
    .grp_o(group), .ptr_adv(ptr_adv)
  );

  // R3: the sequential input is dead in CPU mode, so the pointer stays
  a_r3_cpu_ptr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_mode |=> $stable(seq_grp));

endmodule

// File: tb/test_vtrig_ctrl.sv
module test_vtrig_ctrl;
  localparam int N  = 32;
  localparam int KW = 8;
  localparam int GW = 5;

  logic          clk = 1'b0;
  logic          rst_n, cpu_mode, seq_in, strobe, busy;
  logic [KW-1:0] key_in;
  logic [GW-1:0] addr;
  logic [N-1:0]  opt_level, opt_hold, opt_retrig, opt_stop;
  logic          start, abort, stop_pulse;
  logic [GW-1:0] group;

  int n_chk = 0;
  int n_fail = 0;
  bit done_f = 1'b0;

  always #4 clk = ~clk;

  vtrig_ctrl #(.N_GRP(N), .KEY_W(KW)) i_vtrig_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_mode(cpu_mode), .key_in(key_in),
    .seq_in(seq_in), .strobe(strobe), .addr(addr),
    .opt_level(opt_level), .opt_hold(opt_hold), .opt_retrig(opt_retrig),
    .opt_stop(opt_stop), .busy(busy), .start(start), .group(group),
    .abort(abort), .stop_pulse(stop_pulse)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic end_play();
    busy = 1'b1; step();
    busy = 1'b0; step();
    step();
  endtask

  initial begin
    rst_n = 1'b0; cpu_mode = 1'b0; seq_in = 1'b0; strobe = 1'b0; busy = 1'b0;
    key_in = '0; addr = '0;
    opt_level = '0; opt_hold = '0; opt_retrig = '0; opt_stop = '0;
    step(); step();
    rst_n = 1'b1; step();
    chk("R1", "start", int'(start), 0);
    chk("R1", "abort", int'(abort), 0);
    chk("R1", "stop", int'(stop_pulse), 0);
    chk("R1", "group", int'(group), 0);

    // R2: every valid key code, all groups edge type
    for (int k = 1; k <= N; k++) begin
      key_in = KW'(k); step();
      chk("R2", "start", int'(start), 1);
      chk("R2", "group", int'(group), k - 1);
      key_in = '0;
      end_play();
    end
    // R2: codes outside 1..32 select nothing
    for (int k = N + 1; k < 256; k++) begin
      key_in = KW'(k); step();
      chk("R2", "start on invalid", int'(start), 0);
    end
    key_in = '0; step();
    chk("R2", "start on zero", int'(start), 0);

    // R5: edge group held past the end does not replay
    key_in = 8'd1; step();
    chk("R5", "start", int'(start), 1);
    busy = 1'b1; step(); busy = 1'b0; step(); step(); step();
    chk("R5", "no replay", int'(start), 0);
    key_in = '0; step();

    // R6: level group replays while held
    opt_level[10] = 1'b1;
    key_in = 8'd11; step();
    chk("R6", "start", int'(start), 1);
    chk("R6", "group", int'(group), 10);
    busy = 1'b1; step(); busy = 1'b0; step(); step();
    chk("R6", "replay", int'(start), 1);
    // R7: unholdable level release keeps playing
    key_in = '0; step();
    chk("R7", "no abort unholdable", int'(abort), 0);
    end_play();

    // R7: holdable level release aborts, and R11: no stop after abort
    opt_level[14] = 1'b1; opt_hold[14] = 1'b1; opt_stop[14] = 1'b1;
    key_in = 8'd15; step();
    chk("R7", "start", int'(start), 1);
    busy = 1'b1; key_in = '0; step();
    chk("R7", "abort", int'(abort), 1);
    step();
    chk("R7", "abort single", int'(abort), 0);
    busy = 1'b0; step();
    chk("R11", "no stop after abort", int'(stop_pulse), 0);
    step();

    // R8: holdable edge group, second edge aborts
    opt_hold[7] = 1'b1;
    key_in = 8'd8; step();
    chk("R8", "start", int'(start), 1);
    busy = 1'b1; key_in = '0; step();
    key_in = 8'd8; step();
    chk("R8", "abort", int'(abort), 1);
    chk("R8", "no start", int'(start), 0);
    key_in = '0; busy = 1'b0; step(); step();

    // R9: retriggerable restarts, non-retriggerable ignores
    opt_retrig[4] = 1'b1;
    key_in = 8'd5; step();
    busy = 1'b1; key_in = '0; step();
    key_in = 8'd5; step();
    chk("R9", "restart", int'(start), 1);
    chk("R9", "restart group", int'(group), 4);
    key_in = '0; end_play();
    key_in = 8'd7; step();
    busy = 1'b1; key_in = '0; step();
    key_in = 8'd7; step();
    chk("R9", "ignored", int'(start), 0);
    chk("R9", "group kept", int'(group), 6);
    key_in = '0; end_play();

    // R10: overlap only out of a level unholdable group
    key_in = 8'd11; step();
    chk("R10", "start", int'(start), 1);
    busy = 1'b1; key_in = 8'd13; step();
    chk("R10", "overlap start", int'(start), 1);
    chk("R10", "overlap group", int'(group), 12);
    key_in = 8'd11; step();
    chk("R10", "no overlap from edge", int'(start), 0);
    chk("R10", "group kept", int'(group), 12);
    key_in = '0; step();
    busy = 1'b0; step(); step();

    // R11: stop pulse enabled / disabled
    opt_stop[2] = 1'b1;
    key_in = 8'd3; step();
    key_in = '0; busy = 1'b1; step();
    busy = 1'b0; step();
    chk("R11", "stop", int'(stop_pulse), 1);
    step();
    chk("R11", "stop single", int'(stop_pulse), 0);
    key_in = 8'd2; step();
    key_in = '0; busy = 1'b1; step();
    busy = 1'b0; step();
    chk("R11", "stop disabled", int'(stop_pulse), 0);
    step();

    // R4: sequential walk with wrap
    opt_level = '0; opt_hold = '0; opt_retrig = '0; opt_stop = '0;
    for (int i = 0; i < N + 2; i++) begin
      seq_in = 1'b1; step();
      chk("R4", "seq start", int'(start), 1);
      chk("R4", "seq group", int'(group), i % N);
      seq_in = 1'b0;
      end_play();
    end
    // R1: reset returns pointer to group 0
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    seq_in = 1'b1; step();
    chk("R1", "pointer after reset", int'(group), 0);
    seq_in = 1'b0; busy = 1'b1; step();
    seq_in = 1'b1; step();
    chk("R4", "ignored seq", int'(start), 0);
    seq_in = 1'b0; busy = 1'b0; step(); step();
    seq_in = 1'b1; step();
    chk("R4", "no advance on ignore", int'(group), 1);
    seq_in = 1'b0; end_play();

    // R3: CPU mode, every address
    cpu_mode = 1'b1;
    for (int a = 0; a < N; a++) begin
      addr = GW'(a); strobe = 1'b1; step();
      chk("R3", "cpu start", int'(start), 1);
      chk("R3", "cpu group", int'(group), a);
      strobe = 1'b0;
      end_play();
    end
    addr = 5'd5; strobe = 1'b1; step();
    chk("R3", "latch group", int'(group), 5);
    addr = 5'd9; step();
    chk("R3", "addr change ignored", int'(start), 0);
    chk("R3", "group held", int'(group), 5);
    strobe = 1'b0; end_play();
    key_in = 8'd1; step();
    chk("R3", "key ignored", int'(start), 0);
    key_in = '0; seq_in = 1'b1; step();
    chk("R3", "seq ignored", int'(start), 0);
    seq_in = 1'b0; step();
    // R7: CPU holdable level, strobe release aborts
    opt_level[20] = 1'b1; opt_hold[20] = 1'b1;
    addr = 5'd20; strobe = 1'b1; step();
    chk("R7", "cpu start", int'(start), 1);
    busy = 1'b1; strobe = 1'b0; step();
    chk("R7", "cpu abort", int'(abort), 1);
    busy = 1'b0; step(); step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    done_f = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_f) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule